// File: doc/BRIEF.md
# Versioned Pipeline State Slots

This block sits between the state-setting front end of a command processor and the pipeline that consumes state. It keeps several complete copies (slots) of a register set. New state values go into a slot that no in-flight draw uses, so state can change while older draws are still running. Each draw leaves the block with only the index of its slot. The pipeline reads the registers it needs through that index.

One slot is always current. Writes land in the current slot until a draw has been issued from it. After that, the next write opens a fresh slot: it takes the lowest-numbered slot that is not current and has no outstanding draws, copies the current contents into it, applies the write and makes it current. Every slot counts its outstanding draws. Downstream units report completions by slot index, and each completion lowers that slot's count. A write that needs a fresh slot when none is free is held back with `cmd_ready` low until a completion frees one.

Top module: `slot_state_versioner`

## Requirements
- R1: After reset every register of every slot reads zero, slot 0 is current, `draw_valid` is low and `cmd_ready` is high.
- R2: A state write (`cmd_is_draw`=0) accepted while no draw has been issued from the current slot updates that slot in place and does not change which slot is current.
- R3: The first state write accepted after a draw from the current slot selects the lowest-indexed free slot, copies all registers of the current slot into it, applies the write there and makes it current. The old slot's contents stay unchanged.
- R4: A draw (`cmd_is_draw`=1) accepted in cycle t produces `draw_valid` high in cycle t+1 with `draw_slot` equal to the slot that was current in cycle t. `draw_valid` is low in every other cycle.
- R5: Each slot counts outstanding draws. An issue from the slot adds one and a completion (`done_valid` with `done_slot`) subtracts one. A slot is free when it is not current and its count is zero.
- R6: A state write that needs a fresh slot while no slot is free sees `cmd_ready` low. It changes no state until a completion frees a slot, and it is accepted in the first cycle after that completion.
- R7: A draw issue and a completion for the same slot in the same cycle leave that slot's count unchanged.
- R8: `rd_data` shows, in the same cycle, register `rd_addr` of slot `rd_slot`, including writes accepted on earlier clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_is_draw | input | 1 | 1 = draw, 0 = state write |
| cmd_addr | input | $clog2(NUM_REGS) | Register index for a state write |
| cmd_data | input | DATA_W | Value for a state write |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| draw_valid | output | 1 | A draw leaves the block |
| draw_slot | output | $clog2(NUM_SLOTS) | Slot index the draw uses |
| done_valid | input | 1 | A downstream unit finished one draw |
| done_slot | input | $clog2(NUM_SLOTS) | Slot of the finished draw |
| rd_slot | input | $clog2(NUM_SLOTS) | Slot selected by the read port |
| rd_addr | input | $clog2(NUM_REGS) | Register selected by the read port |
| rd_data | output | DATA_W | Selected register value |

## Verification
A wrong count or a wrong current-slot pointer shows at the ports within a few cycles. A slot that is freed too early lets a stalled write through one cycle early and puts that slot's index on the next draw. A slot that is freed too late holds `cmd_ready` low after the freeing completion. A faulty copy appears on the read port on the cycle after the allocating write. The bench keeps its own model of slots, counts and pointer, and compares `cmd_ready`, `rd_data`, `draw_valid` and `draw_slot` with it on every cycle.

// File: rtl/slot_ver_pkg.sv
package slot_ver_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_DRAW,
    ACT_WR_HERE,
    ACT_WR_NEW,
    ACT_STALL
  } act_e;

  // index of the lowest set bit, 0 when none is set
  function automatic int first_set(logic [31:0] m);
    int r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/slot_counters.sv
module slot_counters #(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic [SLOT_W-1:0] inc_slot,
  input  logic              dec_en,
  input  logic [SLOT_W-1:0] dec_slot,
  output logic [CNT_W-1:0]  cnt [NUM_SLOTS]
);

  function automatic logic [CNT_W-1:0] step_count(logic [CNT_W-1:0] c, logic up, logic down);
    case ({up, down})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [CNT_W-1:0] c_q;
    logic             hit_inc;
    logic             hit_dec;

    assign hit_inc = inc_en && (inc_slot == SLOT_W'(s));
    // a completion for an idle slot is dropped
    assign hit_dec = dec_en && (dec_slot == SLOT_W'(s)) && (c_q != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) c_q <= '0;
      else        c_q <= step_count(c_q, hit_inc, hit_dec);
    end

    assign cnt[s] = c_q;
  end

endmodule

// File: rtl/slot_regfile.sv
module slot_regfile #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              copy_en,
  input  logic [SLOT_W-1:0] src_slot,
  input  logic [SLOT_W-1:0] dst_slot,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  function automatic logic [DATA_W-1:0] pick_word(logic hit, logic [DATA_W-1:0] nv,
                                                  logic [DATA_W-1:0] ov);
    return hit ? nv : ov;
  endfunction

  logic [DATA_W-1:0] store   [NUM_SLOTS][NUM_REGS];
  logic [DATA_W-1:0] src_row [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_src
    assign src_row[r] = store[src_slot][r];
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [DATA_W-1:0] q;
      logic              addr_hit;
      logic              upd;

      assign addr_hit = (wr_addr == ADDR_W'(r));
      assign upd      = wr_en && (dst_slot == SLOT_W'(s)) && (copy_en || addr_hit);

      always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (upd) q <= pick_word(addr_hit, wr_data, src_row[r]);
      end

      assign store[s][r] = q;
    end
  end

  assign rd_data = store[rd_slot][rd_addr];

endmodule

// File: rtl/slot_state_versioner.sv
module slot_state_versioner #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_is_draw,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              cmd_ready,
  output logic              draw_valid,
  output logic [SLOT_W-1:0] draw_slot,
  input  logic              done_valid,
  input  logic [SLOT_W-1:0] done_slot,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import slot_ver_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SLOT_W-1:0]    cur_q;
  logic                 locked_q;
  logic                 draw_valid_q;
  logic [SLOT_W-1:0]    draw_slot_q;
  logic [CNT_W-1:0]     cnt_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] free_mask;
  logic [SLOT_W-1:0]    alloc_slot;
  logic                 any_free;
  act_e                 act;

  // named events for the checker
  logic draw_fire, wr_here_fire, alloc_fire, stall_now;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_free
    assign free_mask[s] = (cur_q != SLOT_W'(s)) && (cnt_q[s] == '0);
  end

  assign any_free   = |free_mask;
  assign alloc_slot = SLOT_W'(first_set(32'(free_mask)));

  always_comb begin
    if (!cmd_valid)                act = ACT_IDLE;
    else if (cmd_is_draw)          act = (cnt_q[cur_q] == CNT_MAX) ? ACT_STALL : ACT_DRAW;
    else if (!locked_q)            act = ACT_WR_HERE;
    else if (any_free)             act = ACT_WR_NEW;
    else                           act = ACT_STALL;
  end

  assign draw_fire    = (act == ACT_DRAW);
  assign wr_here_fire = (act == ACT_WR_HERE);
  assign alloc_fire   = (act == ACT_WR_NEW);
  assign stall_now    = (act == ACT_STALL);
  assign cmd_ready    = !stall_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q        <= '0;
      locked_q     <= 1'b0;
      draw_valid_q <= 1'b0;
      draw_slot_q  <= '0;
    end else begin
      draw_valid_q <= draw_fire;
      if (draw_fire) begin
        draw_slot_q <= cur_q;
        locked_q    <= 1'b1;
      end
      if (alloc_fire) begin
        cur_q    <= alloc_slot;
        locked_q <= 1'b0;
      end
    end
  end

  assign draw_valid = draw_valid_q;
  assign draw_slot  = draw_slot_q;

  slot_counters #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_en   (draw_fire),
    .inc_slot (cur_q),
    .dec_en   (done_valid),
    .dec_slot (done_slot),
    .cnt      (cnt_q)
  );

  slot_regfile #(.NUM_SLOTS(NUM_SLOTS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_here_fire || alloc_fire),
    .copy_en  (alloc_fire),
    .src_slot (cur_q),
    .dst_slot (alloc_fire ? alloc_slot : cur_q),
    .wr_addr  (cmd_addr),
    .wr_data  (cmd_data),
    .rd_slot  (rd_slot),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/slot_state_versioner_chk.sv
module slot_state_versioner_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              draw_valid,
  input logic [SLOT_W-1:0] draw_slot,
  input logic              done_valid,
  input logic [SLOT_W-1:0] done_slot,
  input logic [SLOT_W-1:0] cur_slot,
  input logic              locked,
  input logic              draw_fire,
  input logic              alloc_fire,
  input logic              stall_now,
  input logic [SLOT_W-1:0] alloc_slot,
  input logic [CNT_W-1:0]  cnt [NUM_SLOTS]
);

  // R4
  draw_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    draw_fire |=> draw_valid && (draw_slot == $past(cur_slot)));

  // R4
  no_stray_draw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !draw_fire |=> !draw_valid);

  // R3
  alloc_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (cur_slot == $past(alloc_slot)) && !locked);

  // R5
  alloc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> (cnt[alloc_slot] == '0) && (alloc_slot != cur_slot));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_now |=> $stable(cur_slot));

  // R7
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_fire && done_valid && (done_slot == cur_slot))
      |=> cnt[$past(cur_slot)] == $past(cnt[cur_slot]));

endmodule

bind slot_state_versioner slot_state_versioner_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .draw_valid (draw_valid),
  .draw_slot  (draw_slot),
  .done_valid (done_valid),
  .done_slot  (done_slot),
  .cur_slot   (cur_q),
  .locked     (locked_q),
  .draw_fire  (draw_fire),
  .alloc_fire (alloc_fire),
  .stall_now  (stall_now),
  .alloc_slot (alloc_slot),
  .cnt        (cnt_q)
);

// File: tb/tb_slot_state_versioner.sv
module tb_slot_state_versioner;
  localparam int NS = 4;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_is_draw;
  logic [2:0]  cmd_addr;
  logic [31:0] cmd_data;
  logic        cmd_ready;
  logic        draw_valid;
  logic [1:0]  draw_slot;
  logic        done_valid;
  logic [1:0]  done_slot;
  logic [1:0]  rd_slot;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;

  always #5 clk = ~clk;

  slot_state_versioner dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_draw(cmd_is_draw),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .draw_valid(draw_valid), .draw_slot(draw_slot), .done_valid(done_valid),
    .done_slot(done_slot), .rd_slot(rd_slot), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_run = 0, n_fail = 0, rdc = 0;
  bit finished = 0;
  bit last_ready;
  int last_slot;

  // reference model
  logic [31:0] m_regs [NS][NR];
  int m_cnt [NS];
  int m_cur, m_ds;
  bit m_locked, m_dv;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_first_free();
    for (int s = 0; s < NS; s++)
      if (s != m_cur && m_cnt[s] == 0) return s;
    return -1;
  endfunction

  function automatic bit m_ready(bit v, bit d);
    if (!v) return 1;
    if (d) return m_cnt[m_cur] != 255;
    if (!m_locked) return 1;
    return m_first_free() >= 0;
  endfunction

  // one clock of stimulus, starting between edges
  task automatic cyc(bit v, bit d, int a, logic [31:0] dat, bit dn, int dns);
    bit exp_r, acc, dec_ok;
    int rs, ra, n;
    cmd_valid = v; cmd_is_draw = d; cmd_addr = 3'(a); cmd_data = dat;
    done_valid = dn; done_slot = 2'(dns);
    rs = rdc % NS; ra = (rdc / NS) % NR; rdc++;
    rd_slot = 2'(rs); rd_addr = 3'(ra);
    #1;
    exp_r = m_ready(v, d);
    last_ready = cmd_ready;
    chk(cmd_ready === exp_r, "R6 ready", 32'(cmd_ready), 32'(exp_r));
    chk(rd_data === m_regs[rs][ra], "R8 read", rd_data, m_regs[rs][ra]);
    @(posedge clk);
    acc = v && exp_r;
    dec_ok = dn && m_cnt[dns] > 0;
    m_dv = 0;
    if (acc && d) begin
      m_dv = 1; m_ds = m_cur; m_locked = 1; m_cnt[m_cur]++;
    end else if (acc) begin
      if (!m_locked) m_regs[m_cur][a] = dat;
      else begin
        n = m_first_free();
        for (int r = 0; r < NR; r++) m_regs[n][r] = m_regs[m_cur][r];
        m_regs[n][a] = dat; m_cur = n; m_locked = 0;
      end
    end
    if (dec_ok) m_cnt[dns]--;
    @(negedge clk);
    cmd_valid = 0; done_valid = 0;
    chk(draw_valid === m_dv, "R4 valid", 32'(draw_valid), 32'(m_dv));
    if (m_dv) begin
      chk(draw_slot === 2'(m_ds), "R4 slot", 32'(draw_slot), 32'(m_ds));
      last_slot = int'(draw_slot);
    end
  endtask

  task automatic rd_chk(int s, int a, logic [31:0] exp, string tag);
    rd_slot = 2'(s); rd_addr = 3'(a);
    #1;
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic wr(int a, logic [31:0] dat); cyc(1, 0, a, dat, 0, 0); endtask
  task automatic drw(); cyc(1, 1, 0, 0, 0, 0); endtask
  task automatic fin(int s); cyc(0, 0, 0, 0, 1, s); endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_cnt[s] = 0;
      for (int r = 0; r < NR; r++) m_regs[s][r] = '0;
    end
    m_cur = 0; m_locked = 0; m_dv = 0; m_ds = 0;
    rst_n = 0; cmd_valid = 0; cmd_is_draw = 0; cmd_addr = 0; cmd_data = 0;
    done_valid = 0; done_slot = 0; rd_slot = 0; rd_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: clean reset state
    #1;
    chk(cmd_ready === 1'b1, "R1 ready", 32'(cmd_ready), 1);
    chk(draw_valid === 1'b0, "R1 draw_valid", 32'(draw_valid), 0);
    for (int s = 0; s < NS; s++)
      for (int r = 0; r < NR; r++) rd_chk(s, r, 32'h0, "R1 zero");

    // R2: in-place writes before any draw
    wr(1, 32'hA1); wr(2, 32'hB2); wr(1, 32'hA0);
    drw();
    chk(last_slot == 0, "R2 slot", 32'(last_slot), 0);
    rd_chk(0, 1, 32'hA0, "R2 in place");

    // R3: first write after draw opens slot 1 with copied contents
    wr(1, 32'hC3);
    rd_chk(1, 1, 32'hC3, "R3 new value");
    rd_chk(1, 2, 32'hB2, "R3 copied");
    rd_chk(0, 1, 32'hA0, "R3 old kept");
    wr(5, 32'h55);   // second write stays in slot 1 (R2)
    drw();
    chk(last_slot == 1, "R3 slot", 32'(last_slot), 1);
    rd_chk(1, 5, 32'h55, "R2 second write");

    // fill slots 2 and 3
    wr(3, 32'hD4); drw();
    chk(last_slot == 2, "R3 slot2", 32'(last_slot), 2);
    wr(6, 32'hE6); drw();
    chk(last_slot == 3, "R3 slot3", 32'(last_slot), 3);

    // R6: no free slot, write held
    for (int i = 0; i < 3; i++) begin
      wr(4, 32'hF7);
      chk(last_ready == 0, "R6 stall", 32'(last_ready), 0);
    end
    rd_chk(3, 4, 32'h0, "R6 untouched");

    // R5: completion frees slot 1, write then allocates it
    fin(1);
    wr(4, 32'hF7);
    chk(last_ready == 1, "R6 released", 32'(last_ready), 1);
    rd_chk(1, 4, 32'hF7, "R5 realloc");
    rd_chk(1, 6, 32'hE6, "R5 copy from slot3");
    drw();
    chk(last_slot == 1, "R5 slot", 32'(last_slot), 1);

    // R7: issue and completion on same slot in one cycle
    cyc(1, 1, 0, 0, 1, 1);
    fin(2);
    wr(0, 32'h99);
    chk(last_ready == 1, "R7 alloc2 ready", 32'(last_ready), 1);
    drw();
    chk(last_slot == 2, "R7 slot2", 32'(last_slot), 2);
    wr(0, 32'h98);
    chk(last_ready == 0, "R7 slot1 busy", 32'(last_ready), 0);
    fin(1);
    wr(0, 32'h98);
    chk(last_ready == 1, "R7 slot1 freed", 32'(last_ready), 1);
    drw();
    chk(last_slot == 1, "R7 slot1", 32'(last_slot), 1);

    // drain and idle traffic
    fin(0); fin(3); fin(2); fin(0);
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule